// File: doc/BRIEF.md
# Shared Two-Master Scratchpad Memory

This block is a 2048-word by 32-bit scratchpad that two bus masters reach through two equal ports. Both ports run from one rising-edge clock. Each port has an enable, a word address, write data, a whole-word write strobe and a registered read bus. Either master can read or write any word in any cycle, and it does not need to know what the other master is doing.

Accesses to the same word from both ports in the same cycle are the hard case, and this block defines the result fully. A port that reads a word while the other port writes it gets the contents from before that edge. The write still stores the complete new word. When both ports write the same word, port A's data is kept. Two registered flags report these two kinds of clash, one cycle after the edge where they happen.

A port that writes gets back the value the word now holds (write-first on its own port). A port that is disabled keeps its read bus and ignores its other inputs. Reset clears the read buses and the flags. Reset leaves the stored words unchanged.

Top module: `scratch_dp_ram`

## Requirements
- R1: Every one of the 2048 word addresses, 0 to 2047, stores its own 32-bit value. A write to one address leaves every other address unchanged.
- R2: A read on a port (`*_en`=1, `*_we`=0) puts the addressed word on that port's `*_rdata` after the same rising edge. That is one cycle of latency.
- R3: When one port writes a word and the other port reads the same address on the same edge, the reading port returns the value stored before that edge.
- R4: The write in an R3 clash is stored in full. A later read of that address returns the new word.
- R5: A port that writes (`*_en`=1, `*_we`=1) shows the word that the address now holds on its own `*_rdata` after that edge.
- R6: When both ports write the same address on one edge, port A's data is stored. Both read buses show port A's data after that edge.
- R7: `clash_rw` is 1 for exactly the one cycle after an edge where one port wrote and the other port read the same address. Otherwise it is 0.
- R8: `clash_ww` is 1 for exactly the one cycle after an edge where both ports wrote the same address. Otherwise it is 0. It is never 1 together with `clash_rw`.
- R9: A port with `*_en`=0 keeps its `*_rdata` and ignores `*_we`, `*_addr` and `*_wdata`. Nothing is written through that port.
- R10: When `rst` is high at a rising edge, both read buses and both flags become 0 after that edge. The stored words are kept.
- R11: Writes from both ports to different addresses on the same edge are both stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A word write strobe |
| a_addr | input | 11 | Port A word address |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A registered read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B word write strobe |
| b_addr | input | 11 | Port B word address |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B registered read data |
| clash_rw | output | 1 | One-cycle pulse: cross-port write and read of one word |
| clash_ww | output | 1 | One-cycle pulse: both ports wrote one word |

## Verification
Each internal fault shows up at the ports one cycle after the edge that causes it. A wrong clash class appears as a bad flag pulse on the next cycle. A read-port mux that picks the wrong source puts new data where old data belongs, or the losing write data on a read bus. A corrupted or lost write is only visible when the word is read again, so the sequence reads every clashed address back on a later cycle. A disabled port that writes anyway is caught by reading that word back later.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // Classification of what the two ports do to one word on one edge
    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_AW_BR  = 2'd1,
        CLS_BW_AR  = 2'd2,
        CLS_WW     = 2'd3
    } clash_e;

endpackage

// File: rtl/dpr_clash_detect.sv
module dpr_clash_detect
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output clash_e            cls_now,
    output logic              flag_rw,
    output logic              flag_ww
);

    logic same_word;
    logic [1:0] op_code;

    assign same_word = a_en && b_en && (a_addr == b_addr);
    assign op_code   = {a_we, b_we};

    always_comb begin
        cls_now = CLS_NONE;
        if (same_word) begin
            unique case (op_code)
                2'b10:   cls_now = CLS_AW_BR;
                2'b01:   cls_now = CLS_BW_AR;
                2'b11:   cls_now = CLS_WW;
                default: cls_now = CLS_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_rw <= 1'b0;
            flag_ww <= 1'b0;
        end else begin
            flag_rw <= (cls_now == CLS_AW_BR) || (cls_now == CLS_BW_AR);
            flag_ww <= (cls_now == CLS_WW);
        end
    end

endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] data_a,
    input  logic              wr_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] data_b,
    output logic [DATA_W-1:0] cur_a,
    output logic [DATA_W-1:0] cur_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Contents before the edge: the reading port captures these (read-first)
    assign cur_a = words[addr_a];
    assign cur_b = words[addr_b];

    // One process owns the array; port A is applied last so it wins
    always_ff @(posedge clk) begin
        if (wr_b) words[addr_b] <= data_b;
        if (wr_a) words[addr_a] <= data_a;
    end

endmodule

// File: rtl/dpr_port_reg.sv
module dpr_port_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [DATA_W-1:0] stored_now,
    input  logic [DATA_W-1:0] landing,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (en) begin
            rdata <= we ? landing : stored_now;
        end
    end

endmodule

// File: rtl/scratch_dp_ram.sv
module scratch_dp_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              clash_rw,
    output logic              clash_ww
);

    localparam int NPORT = 2;

    clash_e            cls;
    logic [DATA_W-1:0] cur_a, cur_b;
    logic [DATA_W-1:0] land_b;
    logic              wr_a, wr_b;

    logic              p_en    [NPORT];
    logic              p_we    [NPORT];
    logic [DATA_W-1:0] p_cur   [NPORT];
    logic [DATA_W-1:0] p_land  [NPORT];
    logic [DATA_W-1:0] p_rdata [NPORT];

    assign wr_a   = a_en && a_we;
    assign wr_b   = b_en && b_we;
    // On a double write of one word, both ports see port A's value
    assign land_b = (cls == CLS_WW) ? a_wdata : b_wdata;

    dpr_clash_detect #(.ADDR_W(ADDR_W)) i_detect (
        .clk     (clk),
        .rst     (rst),
        .a_en    (a_en),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .b_en    (b_en),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .cls_now (cls),
        .flag_rw (clash_rw),
        .flag_ww (clash_ww)
    );

    dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk    (clk),
        .wr_a   (wr_a),
        .addr_a (a_addr),
        .data_a (a_wdata),
        .wr_b   (wr_b),
        .addr_b (b_addr),
        .data_b (b_wdata),
        .cur_a  (cur_a),
        .cur_b  (cur_b)
    );

    assign p_en[0]   = a_en;
    assign p_we[0]   = a_we;
    assign p_cur[0]  = cur_a;
    assign p_land[0] = a_wdata;
    assign p_en[1]   = b_en;
    assign p_we[1]   = b_we;
    assign p_cur[1]  = cur_b;
    assign p_land[1] = land_b;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        dpr_port_reg #(.DATA_W(DATA_W)) i_preg (
            .clk        (clk),
            .rst        (rst),
            .en         (p_en[g]),
            .we         (p_we[g]),
            .stored_now (p_cur[g]),
            .landing    (p_land[g]),
            .rdata      (p_rdata[g])
        );
    end

    assign a_rdata = p_rdata[0];
    assign b_rdata = p_rdata[1];

endmodule

// File: rtl/scratch_dp_ram_chk.sv
module scratch_dp_ram_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              a_en,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_wdata,
    input logic [DATA_W-1:0] a_rdata,
    input logic              b_en,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_wdata,
    input logic [DATA_W-1:0] b_rdata,
    input logic              clash_rw,
    input logic              clash_ww
);

    logic same_word;
    assign same_word = a_en && b_en && (a_addr == b_addr);

    AST_RW_PULSE: assert property (@(posedge clk) disable iff (rst)
        (same_word && (a_we != b_we)) |=> clash_rw);                      // R7

    AST_RW_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(same_word && (a_we != b_we)) |=> !clash_rw);                    // R7

    AST_WW_PULSE: assert property (@(posedge clk) disable iff (rst)
        (same_word && a_we && b_we) |=> (clash_ww && !clash_rw));         // R8

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({clash_rw, clash_ww}) <= 1);                           // R8

    AST_A_ECHO: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we) |=> (a_rdata == $past(a_wdata)));                  // R5

    AST_WW_A_WINS: assert property (@(posedge clk) disable iff (rst)
        (same_word && a_we && b_we) |=> (b_rdata == $past(a_wdata)));     // R6

    AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        !a_en |=> $stable(a_rdata));                                      // R9

    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> $stable(b_rdata));                                      // R9

endmodule

bind scratch_dp_ram scratch_dp_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_scratch_dp_ram.sv
module test_scratch_dp_ram;

    localparam int AW = 11;
    localparam int DW = 32;

    typedef struct packed {
        logic          a_en;
        logic          a_we;
        logic [AW-1:0] a_addr;
        logic [DW-1:0] a_wd;
        logic          b_en;
        logic          b_we;
        logic [AW-1:0] b_addr;
        logic [DW-1:0] b_wd;
        logic [DW-1:0] exp_a;
        logic [DW-1:0] exp_b;
        logic          exp_rw;
        logic          exp_ww;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 13;

    localparam vec_t VEC [NV] = '{
        // R5 A writes 5, B untouched after reset (R9)
        '{1'b1,1'b1,11'd5,32'h1111_0005, 1'b0,1'b0,11'd0,32'h0,          32'h1111_0005,32'h0,          1'b0,1'b0,8'd5},
        // R11 both write different words
        '{1'b1,1'b1,11'd7,32'h3333_0007, 1'b1,1'b1,11'd9,32'h2222_0009, 32'h3333_0007,32'h2222_0009,1'b0,1'b0,8'd11},
        // R2 plain reads
        '{1'b1,1'b0,11'd5,32'h0,          1'b1,1'b0,11'd9,32'h0,          32'h1111_0005,32'h2222_0009,1'b0,1'b0,8'd2},
        // R3 A writes 5 while B reads 5: B gets old word, R7 flag
        '{1'b1,1'b1,11'd5,32'h4444_0005, 1'b1,1'b0,11'd5,32'h0,          32'h4444_0005,32'h1111_0005,1'b1,1'b0,8'd3},
        // R4 new word kept; R7 flag drops
        '{1'b1,1'b0,11'd5,32'h0,          1'b1,1'b0,11'd7,32'h0,          32'h4444_0005,32'h3333_0007,1'b0,1'b0,8'd4},
        // R3 B writes 7 while A reads 7
        '{1'b1,1'b0,11'd7,32'h0,          1'b1,1'b1,11'd7,32'h5555_0007, 32'h3333_0007,32'h5555_0007,1'b1,1'b0,8'd3},
        // R6 both write 9, A wins; R8 flag
        '{1'b1,1'b1,11'd9,32'h6666_0009, 1'b1,1'b1,11'd9,32'h7777_0009, 32'h6666_0009,32'h6666_0009,1'b0,1'b1,8'd6},
        // R9 A disabled with write strobe; B reads 9
        '{1'b0,1'b1,11'd9,32'hDEAD_BEEF, 1'b1,1'b0,11'd9,32'h0,          32'h6666_0009,32'h6666_0009,1'b0,1'b0,8'd9},
        // R4 B's clashing write to 7 landed; B disabled holds
        '{1'b1,1'b0,11'd7,32'h0,          1'b0,1'b0,11'd7,32'h0,          32'h5555_0007,32'h6666_0009,1'b0,1'b0,8'd4},
        // R1 extreme addresses
        '{1'b1,1'b1,11'd2047,32'h8888_07FF,1'b1,1'b1,11'd0,32'h9999_0000, 32'h8888_07FF,32'h9999_0000,1'b0,1'b0,8'd1},
        '{1'b1,1'b0,11'd0,32'h0,          1'b1,1'b0,11'd2047,32'h0,       32'h9999_0000,32'h8888_07FF,1'b0,1'b0,8'd1},
        // R3 A reads 9 (proves R9 ignored write) while B writes 9
        '{1'b1,1'b0,11'd9,32'h0,          1'b1,1'b1,11'd9,32'hAAAA_0009, 32'h6666_0009,32'hAAAA_0009,1'b1,1'b0,8'd3},
        // R4 read back
        '{1'b1,1'b0,11'd9,32'h0,          1'b0,1'b0,11'd0,32'h0,          32'hAAAA_0009,32'hAAAA_0009,1'b0,1'b0,8'd4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic          clash_rw, clash_ww;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    scratch_dp_ram i_scratch_dp_ram (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .clash_rw(clash_rw), .clash_ww(clash_ww)
    );

    task automatic check(input string what, input int rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic ae, input logic awe, input logic [AW-1:0] aa, input logic [DW-1:0] awd,
                         input logic be, input logic bwe, input logic [AW-1:0] ba, input logic [DW-1:0] bwd);
        a_en = ae; a_we = awe; a_addr = aa; a_wdata = awd;
        b_en = be; b_we = bwe; b_addr = ba; b_wdata = bwd;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("a_rdata after reset", 10, a_rdata, '0);
        check("b_rdata after reset", 10, b_rdata, '0);
        check("clash_rw after reset", 10, {31'b0, clash_rw}, '0);
        check("clash_ww after reset", 10, {31'b0, clash_ww}, '0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].a_en, VEC[i].a_we, VEC[i].a_addr, VEC[i].a_wd,
                  VEC[i].b_en, VEC[i].b_we, VEC[i].b_addr, VEC[i].b_wd);
            @(negedge clk);
            check($sformatf("vec %0d a_rdata", i), VEC[i].req, a_rdata, VEC[i].exp_a);
            check($sformatf("vec %0d b_rdata", i), VEC[i].req, b_rdata, VEC[i].exp_b);
            check($sformatf("vec %0d clash_rw", i), 7, {31'b0, clash_rw}, {31'b0, VEC[i].exp_rw});
            check($sformatf("vec %0d clash_ww", i), 8, {31'b0, clash_ww}, {31'b0, VEC[i].exp_ww});
        end

        // R10 reset right after a clash: outputs clear, memory kept
        drive(1'b1, 1'b1, 11'd3, 32'hCAFE_0003, 1'b1, 1'b0, 11'd3, 32'h0);
        @(negedge clk);
        check("pre-reset clash_rw", 7, {31'b0, clash_rw}, 32'd1);
        drive(1'b0, 1'b0, 11'd0, 32'h0, 1'b0, 1'b0, 11'd0, 32'h0);
        rst = 1'b1;
        @(negedge clk);
        check("a_rdata in reset", 10, a_rdata, '0);
        check("b_rdata in reset", 10, b_rdata, '0);
        check("clash_rw in reset", 10, {31'b0, clash_rw}, '0);
        rst = 1'b0;
        drive(1'b1, 1'b0, 11'd3, 32'h0, 1'b1, 1'b0, 11'd2047, 32'h0);
        @(negedge clk);
        check("word 3 survives reset", 10, a_rdata, 32'hCAFE_0003);
        check("word 2047 survives reset", 10, b_rdata, 32'h8888_07FF);

        // R1 sweep: distinct pattern in every 64th word, then read back
        for (int k = 0; k < 2048; k += 64) begin
            drive(1'b1, 1'b1, k[AW-1:0], 32'h5A00_0000 ^ k, 1'b0, 1'b0, 11'd0, 32'h0);
            @(negedge clk);
        end
        for (int k = 0; k < 2048; k += 64) begin
            drive(1'b0, 1'b0, 11'd0, 32'h0, 1'b1, 1'b0, k[AW-1:0], 32'h0);
            @(negedge clk);
            check($sformatf("sweep word %0d", k), 1, b_rdata, 32'h5A00_0000 ^ k);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule